// File: doc/BRIEF.md
# CPU Clock Control Unit

This block turns a selected oscillator clock into the enables that pace a small processor core. A divider register sets how many oscillator cycles make up one CPU clock period. Every output is a one-cycle enable in the oscillator clock domain, so no derived clock nets are needed. Software may rewrite the divider at any moment. The new ratio is applied only at the end of the period in progress, so no period is ever cut short.

After reset or a wake request, the CPU enable is held off until a start-up count has run out. The count is long when the crystal source is selected and short for every other source. A ready flag shows when the count has expired. A peripheral enable runs at half the CPU rate.

An optional clock output toggles at half the CPU rate. It is forced low whenever the crystal drives the CPU or the real-time clock. A low-power flag can be set only while the CPU rate, worked out from the oscillator frequency parameter and the current ratio, is at or below the low-power limit.

Top module: `cpu_clk_ctrl`

## Requirements
- R1: With divider value N = 0, `cpu_en_o` is high on every cycle while ready. With N in 1..255, `cpu_en_o` pulses exactly once every 2×N cycles, which gives a largest ratio of 510.
- R2: A divider write does not shorten the CPU clock period in progress. That period ends at its old length, and the next period uses the new ratio.
- R3: Source code 2'b11 is the crystal. When it is selected and a wake request is sampled, `ready_o` falls on the next cycle and rises XTAL_CNT (992) cycles after the wake edge. `cpu_en_o` stays low while `ready_o` is low.
- R4: Source codes 2'b00 (RC), 2'b01 (watchdog oscillator) and 2'b10 (external input) use SHORT_CNT (32) instead. After reset is released, the count is loaded on the first edge, and ready rises SHORT_CNT+1 edges after release.
- R5: `per_en_o` pulses on every second `cpu_en_o` pulse. The first CPU pulse after ready does not carry it, and the second does.
- R6: When the output is enabled and allowed, `clkout_o` toggles on the edge that ends each `cpu_en_o` cycle and holds its value otherwise. Its frequency is therefore half the CPU rate.
- R7: `clkout_o` is low when the output enable is 0, when the source is 2'b11, or when `rtc_xtal_i` is 1.
- R8: `lowpwr_o` resets to 0. Writing 1 sets it only when OSC_KHZ ÷ ratio ≤ LP_MAX_KHZ, where ratio is 1 for N = 0 and 2×N otherwise. Otherwise the write has no effect. Writing 0 always clears it.
- R9: Reset clears the divider to 0, the clock-output enable to 0 and the low-power flag to 0, and restarts the start-up count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Selected oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wake_i | input | 1 | Wake request; restarts the start-up count |
| src_sel_i | input | 2 | Source code: 00 RC, 01 watchdog osc, 10 external, 11 crystal |
| div_we_i | input | 1 | Divider register write strobe |
| div_wdata_i | input | DIV_W | Divider value N |
| cfg_we_i | input | 1 | Control bit write strobe |
| cfg_clkout_en_i | input | 1 | Clock-output enable value |
| cfg_lowpwr_i | input | 1 | Low-power request value |
| rtc_xtal_i | input | 1 | Real-time clock runs from the crystal |
| cpu_en_o | output | 1 | CPU clock enable |
| per_en_o | output | 1 | Peripheral clock enable |
| clkout_o | output | 1 | Half-rate clock output |
| ready_o | output | 1 | Start-up count expired |
| lowpwr_o | output | 1 | Low-power flag |

## Verification
On every cycle, the assertions check the following: the CPU and peripheral enables stay inside ready, ready falls after a wake, the divider ratio changes only at a period boundary, the clock output is low when gated and toggles on each tick, and the low-power flag rises only when permitted. Only the bench scenarios can show the exact start-up lengths, the exact period lengths across rewrites in the middle of a period, and the state that reset restores. The scoreboard measures the intervals between CPU enables and compares them with queued values.

// File: rtl/ccc_pkg.sv
package ccc_pkg;
  typedef enum logic [1:0] {
    SRC_RC   = 2'b00,
    SRC_WDO  = 2'b01,
    SRC_EXT  = 2'b10,
    SRC_XTAL = 2'b11
  } src_e;
endpackage

// File: rtl/ccc_startup.sv
module ccc_startup #(
  parameter int XTAL_CNT  = 992,
  parameter int SHORT_CNT = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wake_i,
  input  logic xtal_i,
  output logic ready_o
);
  localparam int SW = $clog2(XTAL_CNT + 1);
  localparam logic [SW-1:0] XL = SW'(XTAL_CNT);
  localparam logic [SW-1:0] SL = SW'(SHORT_CNT);

  logic [SW-1:0] cnt_q;
  logic          pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b1;
    end else if (pend_q || wake_i) begin
      cnt_q  <= xtal_i ? XL : SL;
      pend_q <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - SW'(1);
    end
  end

  assign ready_o = !pend_q && (cnt_q == '0);

  // R3
  wake_drops_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> !ready_o);
  // R4
  ready_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !wake_i) |=> ready_o);
endmodule

// File: rtl/ccc_divider.sv
module ccc_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             we_i,
  input  logic [DIV_W-1:0] wdata_i,
  output logic             tick_o,
  output logic [DIV_W-1:0] div_o
);
  localparam int CW = DIV_W + 1;

  logic [DIV_W-1:0] nxt_q, act_q;
  logic [CW-1:0]    cnt_q;
  logic [CW-1:0]    last;
  logic             tc, load;

  assign last   = {act_q, 1'b0} - CW'(1);
  assign tc     = (act_q == '0) || (cnt_q == last);
  assign tick_o = run_i && tc;
  // ratio is only committed at a period boundary or while halted
  assign load   = !run_i || tc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) nxt_q <= '0;
    else if (we_i) nxt_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      act_q <= nxt_q;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign div_o = act_q;

  // R1
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q != '0) |-> (cnt_q < {act_q, 1'b0}));
  // R2
  ratio_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_q) |-> $past(load));
endmodule

// File: rtl/ccc_clkout.sv
module ccc_clkout (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  input  logic allow_i,
  output logic per_en_o,
  output logic clkout_o
);
  logic ph_q, co_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= 1'b0;
    else if (!run_i) ph_q <= 1'b0;
    else if (tick_i) ph_q <= !ph_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) co_q <= 1'b0;
    else if (!allow_i) co_q <= 1'b0;
    else if (tick_i) co_q <= !co_q;
  end

  assign per_en_o = tick_i && ph_q;
  assign clkout_o = co_q;

  // R5
  per_in_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_en_o |-> tick_i);
  // R7
  gated_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !allow_i |=> !clkout_o);
  // R6
  toggle_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && allow_i) |=> (clkout_o != $past(clkout_o)));
endmodule

// File: rtl/cpu_clk_ctrl.sv
module cpu_clk_ctrl
  import ccc_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int XTAL_CNT   = 992,
  parameter int SHORT_CNT  = 32,
  parameter int OSC_KHZ    = 18000,
  parameter int LP_MAX_KHZ = 8000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wake_i,
  input  logic [1:0]       src_sel_i,
  input  logic             div_we_i,
  input  logic [DIV_W-1:0] div_wdata_i,
  input  logic             cfg_we_i,
  input  logic             cfg_clkout_en_i,
  input  logic             cfg_lowpwr_i,
  input  logic             rtc_xtal_i,
  output logic             cpu_en_o,
  output logic             per_en_o,
  output logic             clkout_o,
  output logic             ready_o,
  output logic             lowpwr_o
);
  src_e             src;
  logic             xtal_sel, ready, tick, allow, lp_ok;
  logic             en_q, lp_q;
  logic [DIV_W-1:0] div_act;
  logic [31:0]      ratio;

  assign src      = src_e'(src_sel_i);
  assign xtal_sel = (src == SRC_XTAL);

  ccc_startup #(.XTAL_CNT(XTAL_CNT), .SHORT_CNT(SHORT_CNT)) u_start (
    .clk_i, .rst_ni, .wake_i, .xtal_i(xtal_sel), .ready_o(ready)
  );

  ccc_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni, .run_i(ready), .we_i(div_we_i), .wdata_i(div_wdata_i),
    .tick_o(tick), .div_o(div_act)
  );

  assign allow = en_q && !xtal_sel && !rtc_xtal_i;

  ccc_clkout u_co (
    .clk_i, .rst_ni, .run_i(ready), .tick_i(tick), .allow_i(allow),
    .per_en_o, .clkout_o
  );

  assign ratio = (div_act == '0) ? 32'd1 : (32'(div_act) << 1);
  assign lp_ok = (32'(OSC_KHZ) <= 32'(LP_MAX_KHZ) * ratio);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
      lp_q <= 1'b0;
    end else if (cfg_we_i) begin
      en_q <= cfg_clkout_en_i;
      if (!cfg_lowpwr_i) lp_q <= 1'b0;
      else if (lp_ok)    lp_q <= 1'b1;
    end
  end

  assign cpu_en_o = tick;
  assign ready_o  = ready;
  assign lowpwr_o = lp_q;

  // R3
  en_needs_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_en_o |-> ready_o);
  // R8
  lp_permitted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lowpwr_o) |-> $past(lp_ok));
endmodule

// File: tb/sim_cpu_clk_ctrl.sv
`timescale 1ns/1ps
module sim_cpu_clk_ctrl;
  localparam int XTAL_CNT  = 992;
  localparam int SHORT_CNT = 32;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wake_i = 0, div_we_i = 0, cfg_we_i = 0, cfg_clkout_en_i = 0;
  logic cfg_lowpwr_i = 0, rtc_xtal_i = 0;
  logic [1:0] src_sel_i = 2'b00;
  logic [7:0] div_wdata_i = '0;
  logic cpu_en_o, per_en_o, clkout_o, ready_o, lowpwr_o;

  int total = 0, bad = 0, cyc = 0, prev = 0;
  bit have_prev = 0;
  int exp_q[$];

  always #10 clk = !clk;

  cpu_clk_ctrl #(.XTAL_CNT(XTAL_CNT), .SHORT_CNT(SHORT_CNT)) u0 (
    .clk_i(clk), .rst_ni, .wake_i, .src_sel_i, .div_we_i, .div_wdata_i,
    .cfg_we_i, .cfg_clkout_en_i, .cfg_lowpwr_i, .rtc_xtal_i,
    .cpu_en_o, .per_en_o, .clkout_o, .ready_o, .lowpwr_o
  );

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic done();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) cyc++;

  // monitor: measures gaps between CPU enables, compares with queued values (R1, R2)
  always @(negedge clk) begin
    if (cpu_en_o) begin
      if (have_prev && exp_q.size() > 0) begin
        int e;
        e = exp_q.pop_front();
        chk((cyc - prev) == e, "R1/R2 period", cyc - prev, e);
      end
      prev = cyc;
      have_prev = 1;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    done();
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // driver: writes N just after a period boundary and queues the gaps expected
  task automatic write_div(int n, int old_r, int new_r, int cnt);
    do begin @(negedge clk); #1; end while (exp_q.size() != 0 || !cpu_en_o);
    step();
    div_we_i = 1; div_wdata_i = 8'(n);
    if (old_r == 1) begin exp_q.push_back(1); exp_q.push_back(1); end
    else exp_q.push_back(old_r);
    for (int i = 0; i < cnt; i++) exp_q.push_back(new_r);
    step();
    div_we_i = 0;
  endtask

  task automatic cfg(bit en, bit lp);
    step();
    cfg_we_i = 1; cfg_clkout_en_i = en; cfg_lowpwr_i = lp;
    step();
    cfg_we_i = 0;
  endtask

  task automatic wait_ready(int exp_n, string req);
    int n = 0;
    while (1) begin
      @(posedge clk); n++;
      if (n == 1) begin #1; wake_i = 0; end
      @(negedge clk);
      if (ready_o || n > 5000) break;
      if (cpu_en_o) chk(0, "R3 enable while not ready", 1, 0);
    end
    chk(n == exp_n, req, n, exp_n);
  endtask

  task automatic check_toggle(int n, string req);
    bit pc, pk;
    @(negedge clk); pc = cpu_en_o; pk = clkout_o;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(clkout_o == (pc ? !pk : pk), req, clkout_o, pc ? !pk : pk);
      pc = cpu_en_o; pk = clkout_o;
    end
  endtask

  task automatic check_low(int n, string req);
    repeat (2) @(posedge clk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(clkout_o == 0, req, clkout_o, 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk(ready_o == 0, "R9 ready in reset", ready_o, 0);
    chk(cpu_en_o == 0, "R9 cpu_en in reset", cpu_en_o, 0);
    chk(clkout_o == 0, "R9 clkout in reset", clkout_o, 0);
    chk(lowpwr_o == 0, "R9 lowpwr in reset", lowpwr_o, 0);
    rst_ni = 1;
    wait_ready(SHORT_CNT + 1, "R4 RC start-up after reset");
    // R1 N=0 every cycle, R5 peripheral on every second
    for (int i = 0; i < 4; i++) begin
      chk(cpu_en_o == 1, "R1 N=0 every cycle", cpu_en_o, 1);
      chk(per_en_o == (i % 2), "R5 per_en phase", per_en_o, i % 2);
      @(negedge clk);
    end

    // R2 rewrites mid-period; R1 ratios including 510
    write_div(3, 1, 6, 3);
    write_div(5, 6, 10, 3);
    write_div(0, 10, 1, 3);
    write_div(255, 1, 510, 2);
    write_div(1, 510, 2, 4);
    drain();

    // R6 clock output toggles per CPU tick
    src_sel_i = 2'b00; rtc_xtal_i = 0;
    cfg(1, 0);
    check_toggle(12, "R6 clkout toggle");
    step(); rtc_xtal_i = 1;
    check_low(6, "R7 low with rtc on crystal");
    step(); rtc_xtal_i = 0; src_sel_i = 2'b11;
    check_low(6, "R7 low with crystal source");
    step(); src_sel_i = 2'b01;
    check_toggle(8, "R6 clkout toggle wdo source");
    cfg(0, 0);
    check_low(6, "R7 low when disabled");

    // R8 low-power permission: 18000/2 > 8000, 18000/4 <= 8000
    cfg(0, 1);
    @(negedge clk);
    chk(lowpwr_o == 0, "R8 set ignored when fast", lowpwr_o, 0);
    write_div(2, 2, 4, 2);
    drain();
    cfg(0, 1);
    @(negedge clk);
    chk(lowpwr_o == 1, "R8 set when slow", lowpwr_o, 1);
    cfg(0, 0);
    @(negedge clk);
    chk(lowpwr_o == 0, "R8 clear", lowpwr_o, 0);

    // R3 crystal wake, R4 watchdog-oscillator wake
    step(); src_sel_i = 2'b11; wake_i = 1;
    wait_ready(XTAL_CNT + 1, "R3 crystal start-up");
    step(); src_sel_i = 2'b01; wake_i = 1;
    wait_ready(SHORT_CNT + 1, "R4 watchdog-osc start-up");

    // R9 reset mid-operation
    src_sel_i = 2'b00;
    cfg(1, 1);
    @(negedge clk);
    chk(lowpwr_o == 1, "R8 set before reset", lowpwr_o, 1);
    rst_ni = 0;
    @(negedge clk);
    chk(ready_o == 0, "R9 ready cleared", ready_o, 0);
    chk(lowpwr_o == 0, "R9 lowpwr cleared", lowpwr_o, 0);
    chk(clkout_o == 0, "R9 clkout cleared", clkout_o, 0);
    rst_ni = 1;
    wait_ready(SHORT_CNT + 1, "R4 restart after reset");
    for (int i = 0; i < 4; i++) begin
      chk(cpu_en_o == 1, "R9 divider cleared", cpu_en_o, 1);
      @(negedge clk);
    end
    check_low(6, "R9 clkout enable cleared");
    done();
  end
endmodule